// File: doc/BRIEF.md
# Timing Event Trigger Fan-out

This block sits behind the receive side of a timing link. On every cycle of the 119 MHz timing clock (the RF master divided by four, one period of 8.4 ns) it may be handed one 16-bit timing word. The low byte is an event code, where zero means that no event is present. The high byte carries distributed data bits, which are passed straight through. Eight trigger channels each watch for one configured event code. Usually this is the 360 Hz fiducial, which is phase locked to the RF.

When a channel sees its code, it waits a programmable number of whole clock periods. It then drives its trigger output high for a programmable number of periods. The delay and the width are both copied from the configuration at the moment the event is accepted. Software may therefore rewrite a channel's settings at any time, and the new values apply from the next matching event. A channel whose enable bit is cleared stays silent.

Top module: `timing_trigger_fanout`

## Requirements
- R1: While rst_n is low at a clock edge, every trigger output and data_bits read 0 after that edge, and any delay or pulse in progress is forgotten.
- R2: An event is accepted only from a word with word_valid high whose low byte word_data[7:0] is nonzero. A word with word_valid low, or with code 0, never starts a channel, even one configured with code 0.
- R3: data_bits takes word_data[15:8] of each valid word one clock edge after the word is sampled, and holds its value while word_valid is low.
- R4: For a word sampled at clock edge k that matches an enabled channel's code, with delay D from ch_delay (20 bits per channel, channel c at bits [20c+19:20c]), the trigger first reads high after edge k+2+D. D=0 therefore gives 2 cycles of latency.
- R5: The trigger stays high for exactly W cycles, where W comes from ch_width (16 bits per channel, channel c at bits [16c+15:16c]). W=0 produces no pulse.
- R6: A matching event that arrives while the channel is still counting its delay restarts the delay from that event, using the configuration current at that time.
- R7: A matching event that arrives while the channel's pulse is high is ignored, and the pulse ends on its original schedule.
- R8: A channel whose ch_enable bit is 0 at a clock edge reads low after that edge and cancels any pending delay or pulse. It accepts no events while the bit is 0.
- R9: Delay and width are captured when the event is accepted. Changes made to them afterwards do not alter the pulse already scheduled.
- R10: The channels are independent. Several channels may share a code with different delays and widths, and each channel c compares ch_code[8c+7:8c] against the event code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one word period per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | word_data carries a word this cycle |
| word_data | input | 16 | Timing word: [7:0] event code, [15:8] data bits |
| ch_enable | input | 8 | Per-channel enable |
| ch_code | input | 64 | Per-channel event code, 8 bits each |
| ch_delay | input | 160 | Per-channel delay in clock periods, 20 bits each |
| ch_width | input | 128 | Per-channel pulse width in clock periods, 16 bits each |
| trig_out | output | 8 | Trigger outputs |
| data_bits | output | 8 | High byte of the last valid word |

## Verification
A single fiducial code is sent to several channels that have different delays, including zero delay and zero width. This separates latency errors from width errors and shows whether the channels are independent. Three further patterns are then applied: a code repeated during the delay, a code repeated during the pulse, and invalid or zero-code words. These tell restart apart from ignore, and show that the qualifier is honoured. Configuration is rewritten and enables are toggled just after an event has been accepted, and a reset is applied while a long delay is pending. This shows whether settings are captured at the event and whether the cancel paths clear all pending state.

// File: rtl/trig_pkg.sv
// Shared definitions for the timing trigger fan-out.
// Assumes an 8-bit event code sits in the low half of each timing word.
package trig_pkg;
    localparam int EV_CODE_W = 8;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_FIRE = 2'd2
    } ch_state_t;
endpackage

// File: rtl/timing_word_decoder.sv
// Registers one timing word per cycle into an event strobe, an event code
// and a held copy of the data byte.
// Assumes: word_data is valid only when word_valid is high; code 0 = no event.
module timing_word_decoder #(
    parameter int CODE_W = trig_pkg::EV_CODE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_valid,
    input  logic [2*CODE_W-1:0] word_data,
    output logic                ev_hit,
    output logic [CODE_W-1:0]   ev_code,
    output logic [CODE_W-1:0]   data_bits
);
    logic [CODE_W-1:0] in_code;
    logic [CODE_W-1:0] in_data;

    // Split the word into its code and data halves.
    always_comb begin
        in_code = word_data[CODE_W-1:0];
        in_data = word_data[2*CODE_W-1:CODE_W];
    end

    // Qualify the event and keep the data byte from the last valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_hit    <= 1'b0;
            ev_code   <= '0;
            data_bits <= '0;
        end else begin
            ev_hit  <= word_valid && (in_code != '0);
            ev_code <= in_code;
            if (word_valid) begin
                data_bits <= in_data;
            end
        end
    end

    assert_invalid_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> !ev_hit);

    assert_zero_code_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_data[CODE_W-1:0] == '0) |=> !ev_hit);

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(data_bits));
endmodule

// File: rtl/trig_channel.sv
// One delayed-trigger channel. Arms on a matching event, counts the captured
// delay in clock periods, then drives a pulse of the captured width.
// Assumes: ev_hit is already qualified (nonzero code, valid word).
// An event during the delay restarts it, an event during the pulse is ignored,
// and a cleared enable cancels everything.
module trig_channel
    import trig_pkg::*;
#(
    parameter int CODE_W = trig_pkg::EV_CODE_W,
    parameter int DLY_W  = 20,
    parameter int WID_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_hit,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              cfg_en,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [WID_W-1:0]  cfg_width,
    output logic              trig
);
    localparam logic [DLY_W-1:0] DLY_ONE = {{(DLY_W-1){1'b0}}, 1'b1};
    localparam logic [WID_W-1:0] WID_ONE = {{(WID_W-1){1'b0}}, 1'b1};

    ch_state_t        state;
    logic [DLY_W-1:0] dly_cnt;
    logic [WID_W-1:0] wid_q;
    logic [WID_W-1:0] wid_cnt;
    logic             match;

    // An accepted event for this channel.
    always_comb match = ev_hit && (ev_code == cfg_code);

    // Channel sequencer: arm, count the delay, fire the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CH_IDLE;
            dly_cnt <= '0;
            wid_q   <= '0;
            wid_cnt <= '0;
            trig    <= 1'b0;
        end else if (!cfg_en) begin
            state <= CH_IDLE;
            trig  <= 1'b0;
        end else begin
            case (state)
                CH_IDLE, CH_WAIT: begin
                    if (match) begin
                        state   <= CH_WAIT;
                        dly_cnt <= cfg_delay;
                        wid_q   <= cfg_width;
                    end else if (state == CH_WAIT) begin
                        if (dly_cnt == '0) begin
                            if (wid_q != '0) begin
                                trig    <= 1'b1;
                                wid_cnt <= wid_q - WID_ONE;
                                state   <= CH_FIRE;
                            end else begin
                                state <= CH_IDLE;
                            end
                        end else begin
                            dly_cnt <= dly_cnt - DLY_ONE;
                        end
                    end
                end
                CH_FIRE: begin
                    if (wid_cnt == '0) begin
                        trig  <= 1'b0;
                        state <= CH_IDLE;
                    end else begin
                        wid_cnt <= wid_cnt - WID_ONE;
                    end
                end
                default: begin
                    state <= CH_IDLE;
                    trig  <= 1'b0;
                end
            endcase
        end
    end

    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !trig);

    assert_rise_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> $past(state) == CH_WAIT);

    assert_pulse_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_FIRE && wid_cnt != '0 && cfg_en) |=> trig);

    assert_fire_ignores_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_FIRE && match && wid_cnt != '0 && cfg_en)
        |=> (state == CH_FIRE && wid_cnt == $past(wid_cnt) - WID_ONE));
endmodule

// File: rtl/timing_trigger_fanout.sv
// Timing event receiver back end: one word decoder feeding NUM_CH
// independent delayed-trigger channels.
// Assumes: one word per timing clock; configuration buses are packed with
// channel c in slice c of each field width.
module timing_trigger_fanout #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = trig_pkg::EV_CODE_W,
    parameter int DLY_W  = 20,
    parameter int WID_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_valid,
    input  logic [2*CODE_W-1:0]      word_data,
    input  logic [NUM_CH-1:0]        ch_enable,
    input  logic [NUM_CH*CODE_W-1:0] ch_code,
    input  logic [NUM_CH*DLY_W-1:0]  ch_delay,
    input  logic [NUM_CH*WID_W-1:0]  ch_width,
    output logic [NUM_CH-1:0]        trig_out,
    output logic [CODE_W-1:0]        data_bits
);
    logic              ev_hit;
    logic [CODE_W-1:0] ev_code;

    timing_word_decoder #(.CODE_W(CODE_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .ev_hit     (ev_hit),
        .ev_code    (ev_code),
        .data_bits  (data_bits)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        trig_channel #(
            .CODE_W (CODE_W),
            .DLY_W  (DLY_W),
            .WID_W  (WID_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_hit    (ev_hit),
            .ev_code   (ev_code),
            .cfg_en    (ch_enable[c]),
            .cfg_code  (ch_code[c*CODE_W +: CODE_W]),
            .cfg_delay (ch_delay[c*DLY_W +: DLY_W]),
            .cfg_width (ch_width[c*WID_W +: WID_W]),
            .trig      (trig_out[c])
        );
    end
endmodule

// File: tb/sim_timing_trigger_fanout.sv
// Bench: a behavioural schedule model (rise/fall cycle numbers per channel)
// compared against the outputs on every cycle.
module sim_timing_trigger_fanout;
    localparam int N = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic           wv;
    logic [15:0]    wd;
    logic [N-1:0]   en;
    logic [N*8-1:0] codes;
    logic [N*20-1:0] dly;
    logic [N*16-1:0] wid;
    wire  [N-1:0]   trig;
    wire  [7:0]     dbits;

    timing_trigger_fanout u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(wv), .word_data(wd),
        .ch_enable(en), .ch_code(codes), .ch_delay(dly), .ch_width(wid),
        .trig_out(trig), .data_bits(dbits)
    );

    integer tests = 0;
    integer fails = 0;
    integer cyc = 0;
    integer wdog = 0;
    integer rise [N];
    integer fall [N];
    logic   pv = 1'b0;
    logic [7:0] pcode = 8'h00;
    logic [N-1:0] exp_t = '0;
    logic [7:0]   exp_d = 8'h00;
    logic chk_on = 1'b0;
    logic done = 1'b0;
    string tag = "R1";

    // Reference schedule, updated on each clock edge from the inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N; c++) begin rise[c] = -1; fall[c] = -1; end
            pv = 1'b0; pcode = 8'h00; exp_d = 8'h00; cyc = 0; exp_t = '0;
        end else begin
            cyc = cyc + 1;
            for (int c = 0; c < N; c++) begin
                if (!en[c]) begin
                    rise[c] = -1; fall[c] = -1;
                end else if (pv && pcode != 8'h00 && pcode == codes[c*8 +: 8]
                             && !(rise[c] <= cyc - 1 && cyc - 1 < fall[c])) begin
                    rise[c] = cyc + 1 + int'(dly[c*20 +: 20]);
                    fall[c] = rise[c] + int'(wid[c*16 +: 16]);
                end
                exp_t[c] = (rise[c] <= cyc) && (cyc < fall[c]);
            end
            pv = wv; pcode = wd[7:0];
            if (wv) exp_d = wd[15:8];
        end
    end

    // Compare on every cycle, away from the clock edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            tests = tests + 2;
            if (trig !== exp_t) begin
                fails = fails + 1;
                $display("FAIL %s trig_out actual %b expected %b cycle %0d", tag, trig, exp_t, cyc);
            end
            if (dbits !== exp_d) begin
                fails = fails + 1;
                $display("FAIL R3 data_bits actual %h expected %h cycle %0d", dbits, exp_d, cyc);
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        wdog = wdog + 1;
        if (wdog > 150000) begin
            tests = tests + 1; fails = fails + 1;
            $display("FAIL watchdog actual %0d expected below 150000 cycles", wdog);
            finish_up();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic v, input logic [15:0] w);
        wv = v; wd = w;
        @(negedge clk);
        wv = 1'b0;
    endtask

    task automatic set_ch(input int c, input logic e, input logic [7:0] k,
                          input int d, input int w);
        en[c] = e;
        codes[c*8 +: 8] = k;
        dly[c*20 +: 20] = 20'(d);
        wid[c*16 +: 16] = 16'(w);
    endtask

    initial begin
        rst_n = 1'b0; wv = 1'b0; wd = 16'h0000;
        en = '0; codes = '0; dly = '0; wid = '0;
        set_ch(0, 1, 8'h01, 0, 1);
        set_ch(1, 1, 8'h01, 3, 4);
        set_ch(2, 1, 8'h01, 10, 0);
        set_ch(3, 1, 8'h2A, 5, 2);
        set_ch(4, 1, 8'h00, 1, 3);
        set_ch(5, 0, 8'h01, 1, 2);
        set_ch(6, 1, 8'h55, 1000, 5);
        set_ch(7, 1, 8'h2A, 2, 6);
        idle(3);
        rst_n = 1'b1;
        // R1: reset state at the ports.
        tests = tests + 1;
        if (trig !== '0 || dbits !== 8'h00) begin
            fails = fails + 1;
            $display("FAIL R1 reset actual %b/%h expected 0/00", trig, dbits);
        end
        chk_on = 1'b1;

        tag = "R4 R5 R10"; send(1, 16'hA501); idle(30);

        tag = "R2"; send(0, 16'h3C01); idle(10);
        send(1, 16'h7700); idle(10);
        tag = "R3"; send(0, 16'h9901); send(1, 16'h1200); idle(5);

        tag = "R6"; send(1, 16'h002A); idle(2); send(1, 16'h002A); idle(25);

        tag = "R7"; set_ch(3, 0, 8'h2A, 5, 2);
        send(1, 16'h002A); idle(5); send(1, 16'h002A); idle(25);

        tag = "R9"; send(1, 16'h0001); idle(1);
        set_ch(1, 1, 8'h01, 8, 1); idle(25);
        send(1, 16'h0001); idle(25);

        tag = "R8"; set_ch(5, 1, 8'h01, 1, 6);
        send(1, 16'h0001); idle(4); en[5] = 1'b0; en[1] = 1'b0; idle(15);
        send(1, 16'h0001); idle(15);
        en[5] = 1'b1; en[1] = 1'b1; idle(20);
        send(1, 16'h0001); idle(25);

        tag = "R4"; send(1, 16'h0055); idle(1020);

        tag = "R1"; send(1, 16'h6655); idle(50);
        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1100);
        send(1, 16'h0101); idle(30);

        finish_up();
    end
endmodule